// File: doc/BRIEF.md
# Interrupt and DMA request routing matrix

This block connects the interrupt and DMA request lines of four peripheral functions onto a small set of shared, lettered output pins. The functions are a floppy disk controller, a parallel port and two UARTs. Software chooses each function's pin by writing 4-bit select codes into three indexed routing registers. These registers accept reads and writes only while configuration mode is active and the index input names them.

A pin is driven only when at least one function is routed to it. Every other pin reports a deasserted output enable, which the pad ring turns into high impedance. Each UART's routed interrupt pin is further gated by that UART's OUT2 modem-control bit. A special code in the second UART's field makes both UARTs share the first UART's pin.

The IRQ pins are numbered 0 to 7 for letters A to H. Pin 6 belongs to the reserved code and is never enabled. The DRQ pins are numbered 0 to 2 for letters A to C.

Top module: `irq_drq_router`

## Requirements
- R1: The routing registers live at indices 0x26 (DMA select), 0x27 (IRQ select for floppy and parallel port) and 0x28 (IRQ select for the UARTs). A write lands only when `cfg_mode_i` is high and `cfg_index_i` matches one of these indices. Any other write is ignored. `cfg_rdata_o` shows the addressed register while in configuration mode and 0 otherwise.
- R2: After reset all three registers read 0x00, and every IRQ and DRQ output enable is low.
- R3: In register 0x26, bits 7:4 route the floppy DRQ and bits 3:0 route the parallel port DRQ. Code 0 selects none, and codes 1, 2 and 3 select DRQ pins 0, 1 and 2.
- R4: In register 0x27, bits 7:4 route the floppy IRQ and bits 3:0 route the parallel port IRQ. Codes 1 to 6 select IRQ pins 0 to 5, code 8 selects pin 7, and code 0 selects none. A routed floppy or parallel port pin is always enabled and carries the request level.
- R5: IRQ code 7, IRQ codes 9 to 15 and DMA codes 4 to 15 select no pin. IRQ pin 6 is never enabled.
- R6: In register 0x28, bits 7:4 route UART1 and bits 3:0 route UART2, using the R4 encoding. A UART's pin is enabled only while that UART's OUT2 is 1, and then it carries the UART's interrupt level.
- R7: UART2 code 15 selects shared mode. UART1's pin is then enabled if either OUT2 bit is 1, and it is high if any UART with OUT2 set has an active interrupt.
- R8: When two functions land on the same pin, the pin is enabled if either of them is enabled, and its level is the OR of the enabled functions' levels.
- R9: A pin whose output enable is low outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mode_i | input | 1 | Configuration mode active |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_index_i | input | 8 | Configuration register index |
| cfg_wdata_i | input | 8 | Write data |
| cfg_rdata_o | output | 8 | Read data of the indexed register |
| fdc_irq_i | input | 1 | Floppy controller interrupt |
| pport_irq_i | input | 1 | Parallel port interrupt |
| uart1_irq_i | input | 1 | UART1 interrupt |
| uart1_out2_i | input | 1 | UART1 OUT2 gate |
| uart2_irq_i | input | 1 | UART2 interrupt |
| uart2_out2_i | input | 1 | UART2 OUT2 gate |
| fdc_drq_i | input | 1 | Floppy controller DMA request |
| pport_drq_i | input | 1 | Parallel port DMA request |
| irq_o | output | 8 | IRQ pin levels A..H |
| irq_oe_o | output | 8 | IRQ pin output enables |
| drq_o | output | 3 | DRQ pin levels A..C |
| drq_oe_o | output | 3 | DRQ pin output enables |

## Verification
The bench targets the codes that must select nothing: IRQ code 7, codes above 8 and DMA codes above 3. A decoder that simply subtracts one would wrap these codes or drive pin 6 instead of tristating. Shared mode is exercised with every OUT2 combination. A design that copied UART1's gating to the shared pin would tristate the pin while only UART2 is enabled, or would let a gated UART assert it. The bench also sends writes outside configuration mode and writes to the unused index 0x29. A register file that ignored the mode or decoded the index loosely would then move live pins. Two functions are collided on one pin to confirm that their levels are ORed rather than one masking the other.

// File: rtl/router_pkg.sv
package router_pkg;
  localparam int CODE_W     = 4;
  localparam int REG_W      = 8;
  localparam int IRQ_RSVD   = 7;
  localparam logic [CODE_W-1:0] SHARE_CODE = 4'hF;

  typedef struct packed {
    logic [CODE_W-1:0] fdc_dma;
    logic [CODE_W-1:0] pport_dma;
    logic [CODE_W-1:0] fdc_irq;
    logic [CODE_W-1:0] pport_irq;
    logic [CODE_W-1:0] uart1_irq;
    logic [CODE_W-1:0] uart2_irq;
  } route_cfg_t;
endpackage

// File: rtl/route_cfg_regs.sv
module route_cfg_regs
  import router_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter logic [IDX_W-1:0] IDX_DMA  = 8'h26,
  parameter logic [IDX_W-1:0] IDX_IRQA = 8'h27,
  parameter logic [IDX_W-1:0] IDX_IRQB = 8'h28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_mode_i,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_index_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0] cfg_rdata_o,
  output route_cfg_t       cfg_o
);
  logic [REG_W-1:0] dma_q, irqa_q, irqb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_q  <= '0;
      irqa_q <= '0;
      irqb_q <= '0;
    end else if (cfg_mode_i && cfg_we_i) begin
      if (cfg_index_i == IDX_DMA)  dma_q  <= cfg_wdata_i;
      if (cfg_index_i == IDX_IRQA) irqa_q <= cfg_wdata_i;
      if (cfg_index_i == IDX_IRQB) irqb_q <= cfg_wdata_i;
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    if (cfg_mode_i) begin
      if (cfg_index_i == IDX_DMA)  cfg_rdata_o = dma_q;
      if (cfg_index_i == IDX_IRQA) cfg_rdata_o = irqa_q;
      if (cfg_index_i == IDX_IRQB) cfg_rdata_o = irqb_q;
    end
  end

  assign cfg_o = {dma_q, irqa_q, irqb_q};
endmodule

// File: rtl/code_decode.sv
module code_decode
  import router_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter bit RSVD_EN  = 1'b1
) (
  input  logic [CODE_W-1:0]   code_i,
  output logic [NUM_PINS-1:0] sel_o
);
  // code k selects pin k-1; code 0 and anything above NUM_PINS select none
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    if (RSVD_EN && (p + 1 == IRQ_RSVD)) begin : g_rsvd
      assign sel_o[p] = 1'b0;
    end else begin : g_live
      assign sel_o[p] = (code_i == CODE_W'(p + 1));
    end
  end
endmodule

// File: rtl/pin_merge.sv
module pin_merge #(
  parameter int NUM_SRC  = 4,
  parameter int NUM_PINS = 8
) (
  input  logic [NUM_SRC-1:0][NUM_PINS-1:0] sel_i,
  input  logic [NUM_SRC-1:0]               en_i,
  input  logic [NUM_SRC-1:0]               lvl_i,
  output logic [NUM_PINS-1:0]              pin_o,
  output logic [NUM_PINS-1:0]              oe_o
);
  always_comb begin
    pin_o = '0;
    oe_o  = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (sel_i[s][p] && en_i[s]) begin
          oe_o[p]  = 1'b1;
          pin_o[p] = pin_o[p] | lvl_i[s];
        end
      end
    end
  end
endmodule

// File: rtl/irq_drq_router.sv
module irq_drq_router
  import router_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int NUM_DRQ = 3,
  parameter int IDX_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_mode_i,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_index_i,
  input  logic [REG_W-1:0]   cfg_wdata_i,
  output logic [REG_W-1:0]   cfg_rdata_o,
  input  logic               fdc_irq_i,
  input  logic               pport_irq_i,
  input  logic               uart1_irq_i,
  input  logic               uart1_out2_i,
  input  logic               uart2_irq_i,
  input  logic               uart2_out2_i,
  input  logic               fdc_drq_i,
  input  logic               pport_drq_i,
  output logic [NUM_IRQ-1:0] irq_o,
  output logic [NUM_IRQ-1:0] irq_oe_o,
  output logic [NUM_DRQ-1:0] drq_o,
  output logic [NUM_DRQ-1:0] drq_oe_o
);
  localparam int IRQ_SRC = 4;
  localparam int DRQ_SRC = 2;

  route_cfg_t cfg_q;

  route_cfg_regs #(.IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni, .cfg_mode_i, .cfg_we_i, .cfg_index_i, .cfg_wdata_i,
    .cfg_rdata_o, .cfg_o(cfg_q)
  );

  // source order: fdc, pport, uart1, uart2
  logic [IRQ_SRC-1:0][CODE_W-1:0]  irq_code;
  logic [IRQ_SRC-1:0][NUM_IRQ-1:0] irq_sel_raw, irq_sel;
  logic [IRQ_SRC-1:0]              irq_en, irq_lvl;
  logic [DRQ_SRC-1:0][CODE_W-1:0]  drq_code;
  logic [DRQ_SRC-1:0][NUM_DRQ-1:0] drq_sel;
  logic                            share;

  assign irq_code = {cfg_q.uart2_irq, cfg_q.uart1_irq, cfg_q.pport_irq, cfg_q.fdc_irq};
  assign drq_code = {cfg_q.pport_dma, cfg_q.fdc_dma};

  for (genvar s = 0; s < IRQ_SRC; s++) begin : g_irq_dec
    code_decode #(.NUM_PINS(NUM_IRQ), .RSVD_EN(1'b1)) u_dec (
      .code_i(irq_code[s]), .sel_o(irq_sel_raw[s])
    );
  end

  for (genvar s = 0; s < DRQ_SRC; s++) begin : g_drq_dec
    code_decode #(.NUM_PINS(NUM_DRQ), .RSVD_EN(1'b0)) u_dec (
      .code_i(drq_code[s]), .sel_o(drq_sel[s])
    );
  end

  // shared mode steers UART2 onto UART1's pin with its own OUT2 gate
  assign share      = (cfg_q.uart2_irq == SHARE_CODE);
  assign irq_sel[0] = irq_sel_raw[0];
  assign irq_sel[1] = irq_sel_raw[1];
  assign irq_sel[2] = irq_sel_raw[2];
  assign irq_sel[3] = share ? irq_sel_raw[2] : irq_sel_raw[3];

  assign irq_en  = {uart2_out2_i, uart1_out2_i, 1'b1, 1'b1};
  assign irq_lvl = {uart2_irq_i, uart1_irq_i, pport_irq_i, fdc_irq_i};

  pin_merge #(.NUM_SRC(IRQ_SRC), .NUM_PINS(NUM_IRQ)) u_irq_merge (
    .sel_i(irq_sel), .en_i(irq_en), .lvl_i(irq_lvl), .pin_o(irq_o), .oe_o(irq_oe_o)
  );

  pin_merge #(.NUM_SRC(DRQ_SRC), .NUM_PINS(NUM_DRQ)) u_drq_merge (
    .sel_i(drq_sel), .en_i(2'b11), .lvl_i({pport_drq_i, fdc_drq_i}),
    .pin_o(drq_o), .oe_o(drq_oe_o)
  );
endmodule

// File: rtl/router_checks.sv
module router_checks #(
  parameter int NUM_IRQ = 8,
  parameter int NUM_DRQ = 3,
  parameter int IDX_W   = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_mode_i,
  input logic               cfg_we_i,
  input logic [IDX_W-1:0]   cfg_index_i,
  input logic [7:0]         cfg_wdata_i,
  input logic [23:0]        cfg_i,
  input logic               uart1_out2_i,
  input logic               uart2_out2_i,
  input logic [NUM_IRQ-1:0] irq_o,
  input logic [NUM_IRQ-1:0] irq_oe_o,
  input logic [NUM_DRQ-1:0] drq_o,
  input logic [NUM_DRQ-1:0] drq_oe_o
);
  p_cfg_locked_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_mode_i) |=> $stable(cfg_i));

  p_dma_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_mode_i && cfg_index_i == IDX_W'(8'h26)) |=> cfg_i[23:16] == $past(cfg_wdata_i));

  p_reset_quiet_r2: assert property (@(posedge clk_i)
    !rst_ni |-> (irq_oe_o == '0 && drq_oe_o == '0));

  p_no_dma_route_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[23:16] == 8'h00) |-> drq_oe_o == '0);

  p_rsvd_pin_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_oe_o[6]);

  p_uart_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!uart1_out2_i && !uart2_out2_i && cfg_i[15:8] == 8'h00) |-> irq_oe_o == '0);

  p_off_is_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & ~irq_oe_o) == '0) && ((drq_o & ~drq_oe_o) == '0));
endmodule

bind irq_drq_router router_checks #(.NUM_IRQ(NUM_IRQ), .NUM_DRQ(NUM_DRQ), .IDX_W(IDX_W)) u_checks (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_mode_i(cfg_mode_i), .cfg_we_i(cfg_we_i),
  .cfg_index_i(cfg_index_i), .cfg_wdata_i(cfg_wdata_i), .cfg_i(cfg_q),
  .uart1_out2_i(uart1_out2_i), .uart2_out2_i(uart2_out2_i),
  .irq_o(irq_o), .irq_oe_o(irq_oe_o), .drq_o(drq_o), .drq_oe_o(drq_oe_o)
);

// File: tb/tb_irq_drq_router.sv
module tb_irq_drq_router;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_mode_i = 0, cfg_we_i = 0;
  logic [7:0] cfg_index_i = 0, cfg_wdata_i = 0, cfg_rdata_o;
  logic fdc_irq_i = 0, pport_irq_i = 0, uart1_irq_i = 0, uart1_out2_i = 0;
  logic uart2_irq_i = 0, uart2_out2_i = 0, fdc_drq_i = 0, pport_drq_i = 0;
  logic [7:0] irq_o, irq_oe_o;
  logic [2:0] drq_o, drq_oe_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_drq_router dut (
    .clk_i(clk), .rst_ni, .cfg_mode_i, .cfg_we_i, .cfg_index_i, .cfg_wdata_i, .cfg_rdata_o,
    .fdc_irq_i, .pport_irq_i, .uart1_irq_i, .uart1_out2_i, .uart2_irq_i, .uart2_out2_i,
    .fdc_drq_i, .pport_drq_i, .irq_o, .irq_oe_o, .drq_o, .drq_oe_o
  );

  typedef struct {
    logic [7:0] rdata, irq, irq_oe;
    logic [2:0] drq, drq_oe;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] sh_dma = 0, sh_ia = 0, sh_ib = 0;

  function automatic int ipin(logic [3:0] c);
    if (c >= 1 && c <= 8 && c != 7) return int'(c) - 1;
    return -1;
  endfunction

  function automatic int dpin(logic [3:0] c);
    if (c >= 1 && c <= 3) return int'(c) - 1;
    return -1;
  endfunction

  // reference model built from the requirements
  function automatic exp_t model(logic [7:0] ridx, string req);
    exp_t e;
    int u1p, u2p;
    e.req = req; e.irq = 0; e.irq_oe = 0; e.drq = 0; e.drq_oe = 0;
    e.rdata = (ridx == 8'h26) ? sh_dma : (ridx == 8'h27) ? sh_ia : (ridx == 8'h28) ? sh_ib : 8'h00;
    u1p = ipin(sh_ib[7:4]);
    u2p = (sh_ib[3:0] == 4'hF) ? u1p : ipin(sh_ib[3:0]);
    if (ipin(sh_ia[7:4]) >= 0) begin e.irq_oe[ipin(sh_ia[7:4])] = 1; e.irq[ipin(sh_ia[7:4])] |= fdc_irq_i; end
    if (ipin(sh_ia[3:0]) >= 0) begin e.irq_oe[ipin(sh_ia[3:0])] = 1; e.irq[ipin(sh_ia[3:0])] |= pport_irq_i; end
    if (u1p >= 0 && uart1_out2_i) begin e.irq_oe[u1p] = 1; e.irq[u1p] |= uart1_irq_i; end
    if (u2p >= 0 && uart2_out2_i) begin e.irq_oe[u2p] = 1; e.irq[u2p] |= uart2_irq_i; end
    if (dpin(sh_dma[7:4]) >= 0) begin e.drq_oe[dpin(sh_dma[7:4])] = 1; e.drq[dpin(sh_dma[7:4])] |= fdc_drq_i; end
    if (dpin(sh_dma[3:0]) >= 0) begin e.drq_oe[dpin(sh_dma[3:0])] = 1; e.drq[dpin(sh_dma[3:0])] |= pport_drq_i; end
    return e;
  endfunction

  task automatic wr(input logic mode, input logic [7:0] idx, input logic [7:0] data);
    cfg_mode_i = mode; cfg_index_i = idx; cfg_wdata_i = data; cfg_we_i = 1;
    @(posedge clk); #1;
    cfg_we_i = 0;
    if (mode) begin
      if (idx == 8'h26) sh_dma = data;
      if (idx == 8'h27) sh_ia = data;
      if (idx == 8'h28) sh_ib = data;
    end
  endtask

  // driver: push the expected item, then let the monitor sample at the negedge
  task automatic chk(input logic [7:0] ridx, input string req);
    cfg_mode_i = 1; cfg_index_i = ridx; #1;
    exp_q.push_back(model(ridx, req));
    @(negedge clk);
    @(posedge clk); #1;
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (cfg_rdata_o !== e.rdata || irq_o !== e.irq || irq_oe_o !== e.irq_oe ||
          drq_o !== e.drq || drq_oe_o !== e.drq_oe) begin
        n_fail++;
        $display("FAIL %s: rdata=%h irq=%b oe=%b drq=%b doe=%b expected rdata=%h irq=%b oe=%b drq=%b doe=%b",
                 e.req, cfg_rdata_o, irq_o, irq_oe_o, drq_o, drq_oe_o,
                 e.rdata, e.irq, e.irq_oe, e.drq, e.drq_oe);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    fdc_irq_i = 1; pport_irq_i = 1; fdc_drq_i = 1; pport_drq_i = 1;
    // R2: reset values and idle pins
    chk(8'h26, "R2 dma reg reset"); chk(8'h27, "R2 irqa reg reset"); chk(8'h28, "R2 irqb reg reset");
    // R1: write outside configuration mode is dropped
    wr(0, 8'h26, 8'h12); chk(8'h26, "R1 write outside cfg mode");
    // R3: DMA mapping
    fdc_drq_i = 1; pport_drq_i = 0;
    wr(1, 8'h26, 8'h21); chk(8'h26, "R3 fdc->B pport->A");
    fdc_drq_i = 0; pport_drq_i = 1; chk(8'h26, "R3 levels follow");
    // R8: both DRQs on pin C
    wr(1, 8'h26, 8'h33); fdc_drq_i = 0; pport_drq_i = 0; chk(8'h26, "R8 shared drq low");
    fdc_drq_i = 1; chk(8'h26, "R8 shared drq or");
    // R5: DMA code 4 and 15 select nothing
    wr(1, 8'h26, 8'h4F); chk(8'h26, "R5 dma out of range");
    // R4: IRQ mapping
    fdc_irq_i = 1; pport_irq_i = 0;
    wr(1, 8'h27, 8'h18); chk(8'h27, "R4 fdc->A pport->H");
    wr(1, 8'h27, 8'h65); chk(8'h27, "R4 fdc->F pport->E");
    // R5: reserved and out-of-range IRQ codes
    wr(1, 8'h27, 8'h79); chk(8'h27, "R5 irq code 7 and 9");
    wr(1, 8'h27, 8'hAF); chk(8'h27, "R5 irq codes A and F");
    // R9: unrouted request stays low
    wr(1, 8'h27, 8'h00); chk(8'h27, "R9 unrouted irq low");
    // R1: unmatched index ignored, reads 0
    wr(1, 8'h29, 8'h55); chk(8'h29, "R1 unmatched index");
    chk(8'h27, "R1 regs unchanged");
    // R6: UART gating by OUT2
    wr(1, 8'h28, 8'h23);
    uart1_irq_i = 1; uart2_irq_i = 1; uart1_out2_i = 0; uart2_out2_i = 0; chk(8'h28, "R6 both out2 off");
    uart1_out2_i = 1; chk(8'h28, "R6 uart1 on");
    uart2_out2_i = 1; uart2_irq_i = 0; chk(8'h28, "R6 uart2 on idle");
    // R7: shared mode, every OUT2 combination
    wr(1, 8'h28, 8'h2F);
    for (int k = 0; k < 16; k++) begin
      {uart1_out2_i, uart2_out2_i, uart1_irq_i, uart2_irq_i} = 4'(k);
      chk(8'h28, "R7 shared mode");
    end
    // R7: shared with UART1 unrouted drives nothing
    wr(1, 8'h28, 8'h0F); uart1_out2_i = 1; uart2_out2_i = 1; uart2_irq_i = 1;
    chk(8'h28, "R7 shared no pin");
    // R8: UART1 and floppy on the same pin
    wr(1, 8'h27, 8'h30); wr(1, 8'h28, 8'h30); fdc_irq_i = 0; uart1_irq_i = 1; uart1_out2_i = 1;
    chk(8'h28, "R8 irq or merge");
    // R1: read outside configuration mode gives 0
    cfg_mode_i = 0; cfg_index_i = 8'h28; #1;
    begin
      exp_t e;
      e = model(8'h29, "R1 read outside cfg");
      exp_q.push_back(e);
    end
    @(negedge clk); @(posedge clk); #1;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule